// File: doc/BRIEF.md
# Microprogram Sequencer with Branch

This block steps a microprogram through a small control store held inside it. A microprogram counter addresses the store, and the store returns a microword at once, with no clock delay. Each microword carries four things: a group of control bits for the datapath, a load bit, a source-select bit and a branch target field. While the load bit is low, the counter moves to the next address. While it is high, the counter takes its next value from a two-way selector. One input of the selector is the branch field of the current word. The other is a routine start address, which a mapping function computes from the opcode register.

A routine ends in one of two ways. It can end by dispatching through the map to the routine of the next opcode. It can also jump to a shared tail somewhere else in the store. The branch field may be narrower than the counter. A branch then replaces only the low bits of the counter and keeps the high bits of the current address, which limits each jump to an aligned window.

The block is used as the control core of a microcoded unit. The surrounding logic presents an opcode and takes the control bits on every step.

Top module: `uc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the counter goes to address 0. The word at address 0 is a dispatch word, so the first step after reset goes to the mapped start address.
- R2: A word with load bit 0 moves the counter to address+1 on the next edge. The values of its select bit and branch field have no effect on this.
- R3: A word with load bit 1 and select 1 (dispatch) loads the start address of the opcode register. `opcode_in` is captured on every rising edge, including edges during reset, so a dispatch uses the opcode that was present at the edge before it.
- R4: The start address is `{opcode, k}`, where k fills the low ADDR_W-OPC_W bits with the value 2. With the defaults, opcode 6 gives 50, 15 gives 122, 11 gives 90, 1 gives 10 and 2 gives 18.
- R5: A word with load bit 1 and select 0 (jump) loads its own branch field. Neither the opcode nor the map has any effect on the target.
- R6: When BR_W < ADDR_W, a jump replaces the low BR_W bits of the counter and keeps the upper ADDR_W-BR_W bits. With BR_W=4, the jump at 53 with field 90 lands on 58.
- R7: `ctl_out` equals the low CTL_W bits of (address XOR 0x5A) for the word being addressed, and it changes on the same edge as the counter.
- R8: In the store, the words at 0 and 14 dispatch, 53 jumps to 90 and 90 jumps to 13. All other words step. Starting from 50, the path is 50, 51, 52, 53, 90, 13, 14, then a dispatch.
- R9: Stepping from the last address (127 by default) wraps around to 0, which then dispatches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_in | input | OPC_W | Opcode to dispatch; registered on every edge |
| upc_addr | output | ADDR_W | Current microprogram address |
| ctl_out | output | CTL_W | Control bits of the current microword |

## Verification
A wrong counter value or a wrong next-address choice shows at `upc_addr` on the very next edge. Because the control bits depend on the address, the same error also shows at `ctl_out` in that cycle. A fault in the select path only shows when a word with load bit 1 is reached. The bench therefore walks a path that passes through jumps, dispatches with several different opcodes, a wrap of the address space and a narrow-field instance. While a jump is taken, the opcode is changed, so that a jump which consults the map gives a visibly wrong target. An opcode capture that is one edge late shows as a dispatch into the routine of the previous opcode.

// File: rtl/uc_seq_pkg.sv
package uc_seq_pkg;

    localparam int DEF_ADDR_W = 7;
    localparam int DEF_OPC_W  = 4;
    localparam int DEF_CTL_W  = 8;

    localparam logic [7:0] CTL_SCRAMBLE = 8'h5A;

    // Fixed control-store layout
    localparam int FETCH_ADDR  = 0;
    localparam int TAIL_ADDR   = 14;
    localparam int JUMP_A_ADDR = 53;
    localparam int JUMP_A_DEST = 90;
    localparam int JUMP_B_DEST = 13;
    localparam int MAP_OFFSET  = 2;

    typedef enum logic {
        NXT_BRANCH = 1'b0,
        NXT_MAP    = 1'b1
    } nxt_src_e;

    typedef struct packed {
        logic     load;
        nxt_src_e src;
    } seq_ctl_t;

    function automatic logic [31:0] ctl_code(input logic [31:0] addr);
        return addr ^ 32'(CTL_SCRAMBLE);
    endfunction

endpackage

// File: rtl/uc_map.sv
module uc_map
    import uc_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OPC_W  = DEF_OPC_W
) (
    input  logic [OPC_W-1:0]  opc,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int LO_W = ADDR_W - OPC_W;

    generate
        if (LO_W > 0) begin : g_pad
            assign start_addr = {opc, LO_W'(MAP_OFFSET)};
        end else begin : g_trunc
            assign start_addr = opc[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/uc_store.sv
module uc_store
    import uc_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BR_W   = DEF_ADDR_W,
    parameter int CTL_W  = DEF_CTL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CTL_W-1:0]  ctl,
    output seq_ctl_t          seq,
    output logic [BR_W-1:0]   br
);
    always_comb begin
        ctl = CTL_W'(ctl_code(32'(addr)));
        // Stepping word: select and branch bits carry junk on purpose
        seq = '{load: 1'b0, src: nxt_src_e'(addr[0])};
        br  = ~BR_W'(addr);
        if (addr == ADDR_W'(FETCH_ADDR)) begin
            seq = '{load: 1'b1, src: NXT_MAP};
            br  = '1;
        end else if (addr == ADDR_W'(TAIL_ADDR)) begin
            seq = '{load: 1'b1, src: NXT_MAP};
            br  = BR_W'(5);
        end else if (addr == ADDR_W'(JUMP_A_ADDR)) begin
            seq = '{load: 1'b1, src: NXT_BRANCH};
            br  = BR_W'(JUMP_A_DEST);
        end else if (addr == ADDR_W'(JUMP_A_DEST)) begin
            seq = '{load: 1'b1, src: NXT_BRANCH};
            br  = BR_W'(JUMP_B_DEST);
        end
    end
endmodule

// File: rtl/uc_next.sv
module uc_next
    import uc_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BR_W   = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] upc,
    input  seq_ctl_t          seq,
    input  logic [BR_W-1:0]   br,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] branch_tgt;

    generate
        if (BR_W < ADDR_W) begin : g_narrow
            assign branch_tgt = {upc[ADDR_W-1:BR_W], br};
        end else begin : g_full
            assign branch_tgt = br[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (!seq.load) begin
            nxt = upc + ADDR_W'(1);
        end else if (seq.src == NXT_MAP) begin
            nxt = start_addr;
        end else begin
            nxt = branch_tgt;
        end
    end
endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
    import uc_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OPC_W  = DEF_OPC_W,
    parameter int CTL_W  = DEF_CTL_W,
    parameter int BR_W   = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode_in,
    output logic [ADDR_W-1:0] upc_addr,
    output logic [CTL_W-1:0]  ctl_out
);
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] upc_d;
    logic [OPC_W-1:0]  opc_q;
    logic [ADDR_W-1:0] map_start;
    seq_ctl_t          word_seq;
    logic [BR_W-1:0]   word_br;

    always_ff @(posedge clk) begin
        opc_q <= opcode_in;
        if (rst) begin
            upc_q <= '0;
        end else begin
            upc_q <= upc_d;
        end
    end

    uc_map #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_map (
        .opc        (opc_q),
        .start_addr (map_start)
    );

    uc_store #(.ADDR_W(ADDR_W), .BR_W(BR_W), .CTL_W(CTL_W)) u_store (
        .addr (upc_q),
        .ctl  (ctl_out),
        .seq  (word_seq),
        .br   (word_br)
    );

    uc_next #(.ADDR_W(ADDR_W), .BR_W(BR_W)) u_next (
        .upc        (upc_q),
        .seq        (word_seq),
        .br         (word_br),
        .start_addr (map_start),
        .nxt        (upc_d)
    );

    assign upc_addr = upc_q;
endmodule

// File: rtl/uc_sequencer_chk.sv
module uc_sequencer_chk #(
    parameter int ADDR_W = 7,
    parameter int BR_W   = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] upc,
    input logic              load,
    input logic              src,
    input logic [BR_W-1:0]   br,
    input logic [ADDR_W-1:0] start
);
    // R1: reset homes the counter
    p_reset_home_r1: assert property (@(posedge clk) rst |=> upc == '0);

    // R2: a stepping word advances by one whatever its other fields hold
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> upc == $past(upc) + ADDR_W'(1));

    // R3: a dispatch takes the mapped start address
    p_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
        (load && src) |=> upc == $past(start));

    // R5: a jump takes its low bits from the branch field
    p_jump_low_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !src) |=> upc[BR_W-1:0] == $past(br));

    generate
        if (BR_W < ADDR_W) begin : g_high
            // R6: a narrow jump keeps the upper counter bits
            p_jump_high_r6: assert property (@(posedge clk) disable iff (rst)
                (load && !src) |=> upc[ADDR_W-1:BR_W] == $past(upc[ADDR_W-1:BR_W]));
        end
    endgenerate
endmodule

bind uc_sequencer uc_sequencer_chk #(.ADDR_W(ADDR_W), .BR_W(BR_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .upc   (upc_q),
    .load  (word_seq.load),
    .src   (word_seq.src),
    .br    (word_br),
    .start (map_start)
);

// File: tb/test_uc_sequencer.sv
`timescale 1ns/1ps
module test_uc_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode_in = 4'd6;
    logic [6:0] upc_addr;
    logic [7:0] ctl_out;
    logic [6:0] upc_nb;
    logic [7:0] ctl_nb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uc_sequencer i_uc_sequencer (
        .clk(clk), .rst(rst), .opcode_in(opcode_in),
        .upc_addr(upc_addr), .ctl_out(ctl_out)
    );

    uc_sequencer #(.BR_W(4)) i_uc_sequencer_narrow (
        .clk(clk), .rst(rst), .opcode_in(opcode_in),
        .upc_addr(upc_nb), .ctl_out(ctl_nb)
    );

    // Entry: {tag[15:12], opcode driven after check[11:8], expected address[7:0]}
    localparam int VEC_N = 24;
    localparam logic [15:0] VEC [VEC_N] = '{
        16'h3632, 16'h2633, 16'h2634, 16'h8935, 16'h535A, 16'h5F0D,
        16'h800E, 16'h407A, 16'h207B, 16'h207C, 16'h207D, 16'h207E,
        16'h2B7F, 16'h9B00, 16'h475A, 16'h510D, 16'h200E, 16'h400A,
        16'h200B, 16'h200C, 16'h220D, 16'h220E, 16'h4212, 16'h2213
    };

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", upc_addr, 0);
        check("R7", ctl_out, 8'h5A);
        check("R1", upc_nb, 0);

        for (int i = 0; i < VEC_N; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(tag_name(int'(VEC[i][15:12])), upc_addr, VEC[i][7:0]);
            check("R7", ctl_out, VEC[i][7:0] ^ 8'h5A);
            if (i < 4) check("R6", upc_nb, VEC[i][7:0]);
            if (i == 4) check("R6", upc_nb, 58);
            if (i == 5) check("R6", upc_nb, 59);
            opcode_in = VEC[i][11:8];
        end

        // R1: reset in mid-run, then dispatch with the opcode held during reset
        @(negedge clk);
        opcode_in = 4'd2;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", upc_addr, 0);
        check("R7", ctl_out, 8'h5A);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", upc_addr, 18);
        check("R1", upc_nb, 18);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule